// File: doc/BRIEF.md
# DMA Interrupt Mask and Status Unit

This block gathers the error and event conditions raised by a DMA engine into a sticky status byte. A second byte holds per-condition enables. The enables decide only whether a condition may pull the active-low interrupt pin. Every DMA condition is treated as fatal. So a condition with its enable at zero is still recorded in status, still raises the pending summary flag, and still stops script execution.

Software reaches the two bytes through a plain byte-wide register port. `cfg_sel` picks the register and `cfg_rd`/`cfg_wr` act as strobes. Read data is combinational from the selected register. A read strobe on the status register clears it at the next clock edge. The engine raises conditions as one-cycle pulses on `evt_i`. It resumes only after software has emptied status and pulsed `restart_i`.

Field positions are shared by both registers:

| Bit | Condition |
|-----|-----------|
| 0 | illegal instruction |
| 1 | reserved |
| 2 | script interrupt instruction |
| 3 | single-step |
| 4 | aborted |
| 5 | bus fault |
| 6 | master data parity error |
| 7 | reserved |

Top module: `dma_irq_gate`

## Requirements
- R1: After reset the enable register reads 0, the status register reads 0, `irq_n_o` is 1, and `dma_pend_o` and `halt_o` are 0.
- R2: A write with `cfg_sel`=0 and `cfg_wr`=1 stores `cfg_wdata` in the enable register for bits 6,5,4,3,2,0. Bits 7 and 1 ignore the write and always read back 0.
- R3: A 1 on `evt_i` at bit 6,5,4,3,2 or 0 sets that status bit at the next edge, whatever the enable value. Pulses on bits 7 and 1 change nothing.
- R4: Status bits are sticky. A set bit remains set until the status register is read.
- R5: A read with `cfg_sel`=1 and `cfg_rd`=1 returns the current status and clears it at that edge. A bit whose event arrives in the same cycle is set after the edge.
- R6: `irq_n_o` is a registered output. After each edge it is 0 exactly when (status AND enable) is nonzero, so one masked condition never hides an unmasked one.
- R7: `dma_pend_o` is 1 exactly when any status bit is set, masked or not.
- R8: `halt_o` rises one edge after any implemented event, whatever the enable value. It falls only at an edge where `restart_i` is 1, status is already 0, and no new event arrives.
- R9: A write with `cfg_sel`=1 leaves status, `dma_pend_o` and `halt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel | input | 1 | Register select: 0 enable, 1 status |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe (clears status when `cfg_sel`=1) |
| cfg_wdata | input | REG_W | Write data |
| cfg_rdata | output | REG_W | Read data of the selected register |
| evt_i | input | REG_W | Condition pulses, one bit per field |
| restart_i | input | 1 | Resume request from software |
| irq_n_o | output | 1 | Interrupt pin, active low, registered |
| dma_pend_o | output | 1 | Any DMA condition pending |
| halt_o | output | 1 | Stop request to the script engine |

## Verification
The bench builds the block with its defaults: an 8-bit register width and the implemented-bit set 0x7D. That makes the full cross product of all 256 enable values with each of the eight single-bit events affordable. The cross product covers reserved positions, masked-only conditions and the pin equation for every pairing. Directed sequences then cover multi-bit stacking, a read colliding with an event, and restart refused while status is nonzero or while an event lands.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W        = 8;
  localparam int B_ILLEGAL    = 0;
  localparam int B_SCRIPT_INT = 2;
  localparam int B_STEP       = 3;
  localparam int B_ABORT      = 4;
  localparam int B_BUS_FAULT  = 5;
  localparam int B_PARITY     = 6;

  localparam logic [REG_W-1:0] IMPL_DEFAULT =
      REG_W'((1 << B_ILLEGAL) | (1 << B_SCRIPT_INT) | (1 << B_STEP) |
             (1 << B_ABORT) | (1 << B_BUS_FAULT) | (1 << B_PARITY));

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dirq_mask_reg.sv
module dirq_mask_reg #(
  parameter int               REG_W = 8,
  parameter logic [REG_W-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] mask_d
);
  // Next value is exported so the pin stage can align with the update.
  assign mask_d = wr_en ? (wdata & IMPL) : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/dirq_status_reg.sv
module dirq_status_reg #(
  parameter int               REG_W = 8,
  parameter logic [REG_W-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt,
  input  logic             clr,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] stat_d,
  output logic             new_evt
);
  logic [REG_W-1:0] evt_live;

  assign evt_live = evt & IMPL;
  assign new_evt  = |evt_live;
  // Clear acts first; an event in the same cycle is ORed back in.
  assign stat_d   = (clr ? '0 : stat_q) | evt_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/dirq_output_stage.sv
module dirq_output_stage #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] stat_d,
  input  logic [REG_W-1:0] mask_d,
  input  logic [REG_W-1:0] stat_q,
  input  logic             new_evt,
  input  logic             restart,
  output logic             irq_n,
  output logic             halt
);
  logic pin_hit;
  logic halt_release;

  assign pin_hit      = |(stat_d & mask_d);
  assign halt_release = restart && (stat_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n <= 1'b1;
      halt  <= 1'b0;
    end else begin
      irq_n <= ~pin_hit;
      if (new_evt)           halt <= 1'b1;
      else if (halt_release) halt <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_gate.sv
module dma_irq_gate #(
  parameter int               REG_W = dma_irq_pkg::REG_W,
  parameter logic [REG_W-1:0] IMPL  = dma_irq_pkg::IMPL_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sel,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic [REG_W-1:0] evt_i,
  input  logic             restart_i,
  output logic             irq_n_o,
  output logic             dma_pend_o,
  output logic             halt_o
);
  import dma_irq_pkg::*;

  logic             mask_wr;
  logic             stat_clr;
  logic [REG_W-1:0] mask_q, mask_d;
  logic [REG_W-1:0] stat_q, stat_d;
  logic             new_evt;

  assign mask_wr  = cfg_wr && (cfg_sel == SEL_MASK);
  assign stat_clr = cfg_rd && (cfg_sel == SEL_STAT);

  dirq_mask_reg #(.REG_W(REG_W), .IMPL(IMPL)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mask_wr),
    .wdata  (cfg_wdata),
    .mask_q (mask_q),
    .mask_d (mask_d)
  );

  dirq_status_reg #(.REG_W(REG_W), .IMPL(IMPL)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_i),
    .clr     (stat_clr),
    .stat_q  (stat_q),
    .stat_d  (stat_d),
    .new_evt (new_evt)
  );

  dirq_output_stage #(.REG_W(REG_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_d  (stat_d),
    .mask_d  (mask_d),
    .stat_q  (stat_q),
    .new_evt (new_evt),
    .restart (restart_i),
    .irq_n   (irq_n_o),
    .halt    (halt_o)
  );

  assign cfg_rdata  = (cfg_sel == SEL_STAT) ? stat_q : mask_q;
  assign dma_pend_o = |stat_q;
endmodule

// File: rtl/dma_irq_gate_chk.sv
module dma_irq_gate_chk #(
  parameter int               REG_W = 8,
  parameter logic [REG_W-1:0] IMPL  = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_sel,
  input logic             cfg_rd,
  input logic [REG_W-1:0] evt_i,
  input logic             restart_i,
  input logic             irq_n_o,
  input logic             dma_pend_o,
  input logic             halt_o,
  input logic [REG_W-1:0] stat,
  input logic [REG_W-1:0] mask
);
  logic rd_stat;
  assign rd_stat = cfg_rd && (cfg_sel == dma_irq_pkg::SEL_STAT);

  a_r6_pin_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o) == (|(stat & mask)));

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & IMPL)) |=> ((stat & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((stat & $past(stat)) == $past(stat)));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ((evt_i & IMPL) == '0)) |=> (stat == '0));

  a_r8_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & IMPL)) |=> halt_o);

  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !restart_i) |=> halt_o);

  a_r7_pend_halts: assert property (@(posedge clk) disable iff (!rst_n)
    dma_pend_o |-> halt_o);
endmodule

bind dma_irq_gate dma_irq_gate_chk #(.REG_W(REG_W), .IMPL(IMPL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_sel    (cfg_sel),
  .cfg_rd     (cfg_rd),
  .evt_i      (evt_i),
  .restart_i  (restart_i),
  .irq_n_o    (irq_n_o),
  .dma_pend_o (dma_pend_o),
  .halt_o     (halt_o),
  .stat       (stat_q),
  .mask       (mask_q)
);

// File: tb/dma_irq_gate_test.sv
`timescale 1ns/1ps
module dma_irq_gate_test;
  localparam int         W    = 8;
  localparam logic [7:0] IMPL = 8'h7D;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_sel = 1'b0, cfg_wr = 1'b0, cfg_rd = 1'b0, restart_i = 1'b0;
  logic [W-1:0] cfg_wdata = '0, evt_i = '0;
  logic [W-1:0] cfg_rdata;
  logic         irq_n_o, dma_pend_o, halt_o;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  dma_irq_gate uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_i(evt_i),
    .restart_i(restart_i), .irq_n_o(irq_n_o), .dma_pend_o(dma_pend_o), .halt_o(halt_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic peek(input logic sel, output logic [7:0] v);
    cfg_sel = sel;
    #0.5 v = cfg_rdata;
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    cfg_sel = sel; cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic pulse(input logic [7:0] e);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic rd_stat(input logic [7:0] e, output logic [7:0] v);
    cfg_sel = 1'b1; cfg_rd = 1'b1; evt_i = e;
    #0.5 v = cfg_rdata;
    @(negedge clk);
    cfg_rd = 1'b0; evt_i = '0;
  endtask

  task automatic restart(input logic [7:0] e);
    restart_i = 1'b1; evt_i = e;
    @(negedge clk);
    restart_i = 1'b0; evt_i = '0;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=running exp=finished");
      report();
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] es;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(1'b0, v); check("R1 mask", v, 0);
    peek(1'b1, v); check("R1 status", v, 0);
    check("R1 irq_n", irq_n_o, 1);
    check("R1 pend", dma_pend_o, 0);
    check("R1 halt", halt_o, 0);

    // Sweep all enable values against every single-bit event
    for (int m = 0; m < 256; m++) begin
      wr_reg(1'b0, 8'(m));
      peek(1'b0, v); check("R2 mask readback", v, 8'(m) & IMPL);
      for (int b = 0; b < 8; b++) begin
        es = (8'd1 << b) & IMPL;
        wr_reg(1'b0, 8'(m));
        pulse(8'd1 << b);
        peek(1'b1, v); check("R3 status capture", v, es);
        check("R6 irq_n", irq_n_o, ((es & 8'(m)) == 0) ? 1 : 0);
        check("R7 pend", dma_pend_o, (es != 0) ? 1 : 0);
        check("R8 halt on event", halt_o, (es != 0) ? 1 : 0);
        rd_stat(8'h00, v); check("R5 read value", v, es);
        peek(1'b1, v); check("R5 cleared", v, 0);
        check("R6 irq_n after clear", irq_n_o, 1);
        restart(8'h00);
        check("R8 halt released", halt_o, 0);
      end
    end

    // R9 write to status is ignored
    wr_reg(1'b1, 8'hFF);
    peek(1'b1, v); check("R9 status unchanged", v, 0);
    check("R9 pend", dma_pend_o, 0);
    check("R9 halt", halt_o, 0);

    // R4 stickiness and stacking
    wr_reg(1'b0, 8'h20);
    pulse(8'h01);
    repeat (5) @(negedge clk);
    peek(1'b1, v); check("R4 sticky", v, 8'h01);
    check("R6 masked only, irq high", irq_n_o, 1);
    pulse(8'h20);
    peek(1'b1, v); check("R4 stacked", v, 8'h21);
    check("R6 unmasked gets through", irq_n_o, 0);

    // R5 read colliding with new event
    rd_stat(8'h08, v); check("R5 read returns old", v, 8'h21);
    peek(1'b1, v); check("R5 collision kept", v, 8'h08);
    check("R6 irq_n masked", irq_n_o, 1);

    // R6 enable change aligns with register update
    wr_reg(1'b0, 8'h08);
    check("R6 irq after enable", irq_n_o, 0);
    wr_reg(1'b0, 8'h00);
    check("R6 irq after disable", irq_n_o, 1);

    // R8 restart refused while status nonzero
    restart(8'h00);
    check("R8 halt held, status set", halt_o, 1);
    rd_stat(8'h00, v);
    check("R7 pend cleared", dma_pend_o, 0);
    check("R8 halt held before restart", halt_o, 1);
    restart(8'h10);
    check("R8 event beats restart", halt_o, 1);
    rd_stat(8'h00, v); check("R5 event read", v, 8'h10);
    restart(8'h00);
    check("R8 halt finally released", halt_o, 0);

    done = 1'b1;
    report();
  end
endmodule